// File: doc/BRIEF.md
# Programmable Two-Stage Clock Post-Scaler

This block turns a fast oscillator clock into a slower loop clock through two dividers in series. The first divider passes one pulse out of every 2^P input cycles, where P is a 2-bit code. The second divider counts those pulses and flips the output after every Q+1 of them, where Q is a 3-bit code, so it divides by the even factor 2(Q+1). The loop clock therefore has a period of 2^P × 2(Q+1) input cycles and a 50% duty cycle for every legal code pair.

Two byte-wide control registers hold the codes. One also carries a run bit, and clearing that bit holds the whole chain idle with its output low. Codes written while the chain runs are parked until the current output period ends, so the loop clock never shows a shortened phase. A separate combinational helper suggests a P and Q pair for a requested total factor Z. For small Z it uses a power-of-two rule. For large Z it pins P at its maximum and clamps Q.

Top module: `lclk_postscaler`

## Requirements
- R1: P is taken from bits 1:0 of the first-stage control byte (wr_sel = 0), and the first stage divides by 2^P, giving 1, 2, 4 or 8.
- R2: Q is taken from bits 2:0 of the second-stage control byte (wr_sel = 1), and the second stage divides by 2(Q+1), giving 2 up to 16.
- R3: While running, with H = 2^P × (Q+1), lclk_out is low for H input cycles and then high for H input cycles, so one period is 2H cycles.
- R4: Bit 7 of the first-stage control byte is the run bit (1 = run). All other bits of both control bytes that are not named in R1 or R2 have no effect on lclk_out.
- R5: Once the run bit is cleared, lclk_out is low and both stage counters are zero no later than the second clock edge after the write, and they stay that way. Once the run bit is set, the first rising edge of lclk_out follows H+1 clock edges after the write.
- R6: A P or Q value written while running takes effect only when the current output period ends, at the falling edge of lclk_out. The period in progress completes with its old H.
- R7: Asserting rst_n low (asynchronous) clears the run bit, P and Q to zero, and forces lclk_out low.
- R8: For z_req of 16 or less, the helper gives sug_q = 0 and sug_p = floor(log2 z_req) limited to 3, with sug_p = 0 for z_req of 0 or 1.
- R9: For z_req above 16, the helper gives sug_p = 3 and sug_q = floor(z_req / 16) − 1, limited to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being divided; also clocks the registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the control bytes |
| wr_sel | input | 1 | 0 = first-stage control byte (run, P), 1 = second-stage control byte (Q) |
| wr_data | input | 8 | Control byte value to write |
| lclk_out | output | 1 | Divided loop clock |
| z_req | input | 8 | Requested total division factor for the helper |
| sug_p | output | 2 | Suggested P code |
| sug_q | output | 3 | Suggested Q code |

## Verification
The hardest situation to reach is a code rewrite that lands partway through an output period. It has to be shown that the old half-periods finish at their full length and that the new H starts exactly at the following falling edge. The bench reaches this by rewriting the codes at randomly chosen cycles inside long running stretches, and adds a directed case that shrinks Q from 7 to 0 in the middle of the low phase. A cycle-level reference model, kept as a single phase counter rather than two cascaded counters, predicts every output sample, including samples taken around run-bit changes and an asynchronous reset.

// File: rtl/lclk_ps_pkg.sv
package lclk_ps_pkg;
  localparam int unsigned PCODE_W = 2;
  localparam int unsigned QCODE_W = 3;
  localparam int unsigned CTL_W   = 8;
  localparam int unsigned RUN_POS = 7;
  localparam int unsigned ZREQ_W  = 8;

  typedef enum logic {
    SEL_STAGE1 = 1'b0,
    SEL_STAGE2 = 1'b1
  } ctl_sel_e;
endpackage

// File: rtl/ps_ctl_regs.sv
module ps_ctl_regs
  import lclk_ps_pkg::*;
#(
  parameter int unsigned P_W     = PCODE_W,
  parameter int unsigned Q_W     = QCODE_W,
  parameter int unsigned D_W     = CTL_W,
  parameter int unsigned RUN_BIT = RUN_POS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [D_W-1:0] wr_data,
  output logic           run,
  output logic [P_W-1:0] p_code,
  output logic [Q_W-1:0] q_code
);
  logic           run_q, run_d;
  logic [P_W-1:0] p_q, p_d;
  logic [Q_W-1:0] q_q, q_d;
  logic           unused_ctl_bits;

  assign unused_ctl_bits = ^wr_data;

  always_comb begin
    run_d = run_q;
    p_d   = p_q;
    q_d   = q_q;
    if (wr_en) begin
      if (ctl_sel_e'(wr_sel) == SEL_STAGE1) begin
        run_d = wr_data[RUN_BIT];
        p_d   = wr_data[P_W-1:0];
      end else begin
        q_d   = wr_data[Q_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      p_q   <= '0;
      q_q   <= '0;
    end else begin
      run_q <= run_d;
      p_q   <= p_d;
      q_q   <= q_d;
    end
  end

  assign run    = run_q;
  assign p_code = p_q;
  assign q_code = q_q;
endmodule

// File: rtl/ps_pow2_stage.sv
module ps_pow2_stage #(
  parameter int unsigned P_W   = 2,
  localparam int unsigned CNT_W = (1 << P_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [P_W-1:0]   p_act,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  assign lim  = ~({CNT_W{1'b1}} << p_act);
  assign tick = en && (cnt_q == lim);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ps_even_stage.sv
module ps_even_stage #(
  parameter int unsigned Q_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic [Q_W-1:0] q_act,
  output logic           clk_out,
  output logic           wrap,
  output logic [Q_W-1:0] cnt
);
  logic [Q_W-1:0] cnt_q, cnt_d;
  logic           out_q, out_d;
  logic           last;

  assign last = (cnt_q == q_act);
  assign wrap = tick && last && out_q;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (!en) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (tick) begin
      if (last) begin
        cnt_d = '0;
        out_d = ~out_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_out = out_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/ps_pick.sv
module ps_pick #(
  parameter int unsigned Z_W = 8,
  parameter int unsigned P_W = 2,
  parameter int unsigned Q_W = 3
) (
  input  logic [Z_W-1:0] z,
  output logic [P_W-1:0] p_sug,
  output logic [Q_W-1:0] q_sug
);
  localparam int unsigned PMAX  = (1 << P_W) - 1;
  localparam int unsigned QMAX  = (1 << Q_W) - 1;
  localparam int unsigned LOG_U = PMAX + 1;
  localparam int unsigned Z_LIM = 1 << LOG_U;

  int unsigned msb;
  int unsigned quo;

  always_comb begin
    msb = 0;
    for (int i = 0; i < Z_W; i++) begin
      if (z[i]) msb = i;
    end
    quo = int'(z) >> LOG_U;
    if (int'(z) <= Z_LIM) begin
      p_sug = (msb > PMAX) ? P_W'(PMAX) : P_W'(msb);
      q_sug = '0;
    end else begin
      p_sug = P_W'(PMAX);
      q_sug = (quo - 1 > QMAX) ? Q_W'(QMAX) : Q_W'(quo - 1);
    end
  end
endmodule

// File: rtl/lclk_postscaler.sv
module lclk_postscaler
  import lclk_ps_pkg::*;
#(
  parameter int unsigned P_W     = PCODE_W,
  parameter int unsigned Q_W     = QCODE_W,
  parameter int unsigned D_W     = CTL_W,
  parameter int unsigned RUN_BIT = RUN_POS,
  parameter int unsigned Z_W     = ZREQ_W,
  localparam int unsigned C1_W   = (1 << P_W) - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [D_W-1:0] wr_data,
  output logic           lclk_out,
  input  logic [Z_W-1:0] z_req,
  output logic [P_W-1:0] sug_p,
  output logic [Q_W-1:0] sug_q
);
  logic            run;
  logic [P_W-1:0]  p_code, act_p, act_p_d;
  logic [Q_W-1:0]  q_code, act_q, act_q_d;
  logic            chain_en;
  logic            tick1, wrap;
  logic [C1_W-1:0] cnt1;
  logic [Q_W-1:0]  cnt2;

  ps_ctl_regs #(.P_W(P_W), .Q_W(Q_W), .D_W(D_W), .RUN_BIT(RUN_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run(run), .p_code(p_code), .q_code(q_code)
  );

  always_comb begin
    act_p_d = act_p;
    act_q_d = act_q;
    if (!chain_en || wrap) begin
      act_p_d = p_code;
      act_q_d = q_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_en <= 1'b0;
      act_p    <= '0;
      act_q    <= '0;
    end else begin
      chain_en <= run;
      act_p    <= act_p_d;
      act_q    <= act_q_d;
    end
  end

  ps_pow2_stage #(.P_W(P_W)) u_stage1 (
    .clk(clk), .rst_n(rst_n), .en(chain_en), .p_act(act_p), .tick(tick1), .cnt(cnt1)
  );

  ps_even_stage #(.Q_W(Q_W)) u_stage2 (
    .clk(clk), .rst_n(rst_n), .en(chain_en), .tick(tick1), .q_act(act_q),
    .clk_out(lclk_out), .wrap(wrap), .cnt(cnt2)
  );

  ps_pick #(.Z_W(Z_W), .P_W(P_W), .Q_W(Q_W)) u_pick (
    .z(z_req), .p_sug(sug_p), .q_sug(sug_q)
  );
endmodule

// File: rtl/lclk_postscaler_chk.sv
module lclk_postscaler_chk #(
  parameter int unsigned P_W  = 2,
  parameter int unsigned Q_W  = 3,
  parameter int unsigned Z_W  = 8,
  localparam int unsigned C1_W = (1 << P_W) - 1,
  localparam int unsigned PMAX = (1 << P_W) - 1,
  localparam int unsigned ZLIM = 1 << (PMAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            tick,
  input logic            wrap,
  input logic            lclk,
  input logic [C1_W-1:0] cnt1,
  input logic [Q_W-1:0]  cnt2,
  input logic [P_W-1:0]  act_p,
  input logic [Q_W-1:0]  act_q,
  input logic [Z_W-1:0]  z,
  input logic [P_W-1:0]  sp,
  input logic [Q_W-1:0]  sq
);
  assert_idle_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!lclk && cnt1 == '0 && cnt2 == '0));

  assert_codes_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(act_p) && $stable(act_q)));

  assert_toggle_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(lclk));

  assert_stage1_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((int'(cnt1) >> act_p) == 0));

  assert_stage2_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt2 <= act_q));

  assert_pick_small_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(z) <= ZLIM) |-> (sq == '0));

  assert_pick_large_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(z) > ZLIM) |-> (int'(sp) == PMAX));
endmodule

bind lclk_postscaler lclk_postscaler_chk #(.P_W(P_W), .Q_W(Q_W), .Z_W(Z_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(chain_en), .tick(tick1), .wrap(wrap), .lclk(lclk_out),
  .cnt1(cnt1), .cnt2(cnt2), .act_p(act_p), .act_q(act_q),
  .z(z_req), .sp(sug_p), .sq(sug_q)
);

// File: tb/lclk_postscaler_test.sv
module lclk_postscaler_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] z_req = 8'h00;
  logic       lclk_out;
  logic [1:0] sug_p;
  logic [2:0] sug_q;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  int  m_run = 0, m_p = 0, m_q = 0, m_en = 0, a_p = 0, a_q = 0, k = 0;
  int  m_out = 0;

  always #5 clk = ~clk;

  lclk_postscaler uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lclk_out(lclk_out), .z_req(z_req), .sug_p(sug_p), .sug_q(sug_q)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_p(int z);
    if (z >= 8) return 3;
    if (z >= 4) return 2;
    if (z >= 2) return 1;
    return 0;
  endfunction

  function automatic int ref_q(int z);
    int t;
    if (z <= 16) return 0;
    t = z / 16 - 1;
    return (t > 7) ? 7 : t;
  endfunction

  task automatic model_reset();
    m_run = 0; m_p = 0; m_q = 0; m_en = 0; a_p = 0; a_q = 0; k = 0; m_out = 0;
  endtask

  // one clock: drive at negedge, model the edge, sample at next negedge
  task automatic cycle(bit w, bit s, logic [7:0] d, string req);
    int h;
    wr_en = w; wr_sel = s; wr_data = d;
    @(posedge clk);
    if (m_en == 0) begin
      k = 0; m_out = 0; a_p = m_p; a_q = m_q;
    end else begin
      k++;
      h = (1 << a_p) * (a_q + 1);
      if (k == 2 * h) begin
        k = 0; m_out = 0; a_p = m_p; a_q = m_q;
      end else begin
        m_out = (k >= h) ? 1 : 0;
      end
    end
    m_en = m_run;
    if (w) begin
      if (!s) begin m_run = d[7]; m_p = int'(d[1:0]); end
      else    m_q = int'(d[2:0]);
    end
    @(negedge clk);
    wr_en = 1'b0;
    check(req, int'(lclk_out), m_out);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 8'h00, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    check("R7", int'(lclk_out), 0);
    rst_n = 1'b1;
    idle(5, "R7");

    // R4/R2: junk upper bits in both bytes; P=1, Q=3 -> H=8
    cycle(1'b1, 1'b1, 8'hF8 | 8'd3, "R4");
    cycle(1'b1, 1'b0, 8'hFC | 8'd1, "R4");
    idle(70, "R2");

    // R1: each P with Q=0, restarting through run=0
    for (int p = 0; p < 4; p++) begin
      cycle(1'b1, 1'b0, 8'h00, "R5");
      cycle(1'b1, 1'b1, 8'h00, "R1");
      cycle(1'b1, 1'b0, 8'h80 | 8'(p), "R1");
      idle(40, "R1");
    end

    // R6: P=0, Q=7 (H=8); shrink Q mid low phase
    cycle(1'b1, 1'b0, 8'h00, "R5");
    cycle(1'b1, 1'b1, 8'h07, "R6");
    cycle(1'b1, 1'b0, 8'h80, "R6");
    idle(4, "R6");
    cycle(1'b1, 1'b1, 8'h00, "R6");
    idle(40, "R6");

    // R5: stop while running, output must settle low and stay low
    cycle(1'b1, 1'b0, 8'h7C, "R5");
    idle(12, "R5");

    // R7: asynchronous reset in the middle of a run
    cycle(1'b1, 1'b0, 8'h81, "R7");
    idle(9, "R3");
    #2 rst_n = 1'b0;
    #1 model_reset();
    check("R7", int'(lclk_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(6, "R7");

    // R3: constrained random segments with stray rewrites
    for (int seg = 0; seg < 150; seg++) begin
      int p  = $urandom_range(0, 3);
      int q  = $urandom_range(0, 7);
      int ln = $urandom_range(20, 300);
      cycle(1'b1, 1'b1, {5'($urandom), 3'(q)}, "R2");
      cycle(1'b1, 1'b0, {1'b1, 5'($urandom), 2'(p)}, "R1");
      for (int c = 0; c < ln; c++) begin
        if ($urandom_range(0, 99) < 3) begin
          logic [7:0] d = 8'($urandom);
          bit sel = 1'($urandom);
          if (!sel && $urandom_range(0, 99) < 85) d[7] = 1'b1;
          cycle(1'b1, sel, d, "R6");
        end else begin
          cycle(1'b0, 1'b0, 8'h00, "R3");
        end
      end
    end

    // R8/R9: helper over every request value
    for (int z = 0; z < 256; z++) begin
      z_req = 8'(z);
      #1;
      if (z <= 16) begin
        check("R8", int'(sug_p), ref_p(z));
        check("R8", int'(sug_q), ref_q(z));
      end else begin
        check("R9", int'(sug_p), 3);
        check("R9", int'(sug_q), ref_q(z));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule